// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block watches the address, chip-enable and write-enable lines of an asynchronous SRAM bus, sampled in the system clock domain. It recognises a fixed, ordered series of six ordinary read cycles to magic addresses. That series is the software request to copy the SRAM into its nonvolatile shadow (a STORE) or to copy the shadow back into the SRAM (a RECALL). The sixth address decides which of the two operations is requested.

When a full series is seen, the block sends a one-cycle command pulse to the copy engine. It then holds an access-inhibit output, and a matching busy flag, for a fixed number of clock cycles that covers the operation. A RECALL runs in two phases. First a clear phase wipes the SRAM, and then a transfer phase loads the shadow contents. Each phase gets its own start pulse.

Any write cycle, or any read to an address the matcher does not expect, abandons the partial series. Bus traffic seen while an operation runs is ignored, and it leaves the matcher at its first step.

Top module: `nvseq_detect`

## Requirements
- R1: After reset, every command pulse, `inhibit_o` and `busy_o` are low, and the matcher waits for the first address of the series.
- R2: Reads to the following addresses, in this order, produce one STORE: FIRST_ADDR, SECOND_ADDR, 0x0AAA, 0x1FFF, 0x10F0, STORE_ADDR. `store_go_o` goes high for exactly one cycle, in the cycle after the clock edge that sees the rising edge of `bus_ce_n` ending the sixth read. `busy_o` and `inhibit_o` then stay high for exactly STORE_CYCLES cycles, starting in that same cycle.
- R3: The same five leading reads followed by a read of 0x0F0E produce one RECALL. `clear_go_o` pulses for one cycle. `xfer_go_o` pulses exactly CLEAR_CYCLES cycles later. `busy_o` and `inhibit_o` stay high for CLEAR_CYCLES + XFER_CYCLES cycles in total.
- R4: A read to an address other than the expected one returns the matcher to its first step, and the series must then start over.
- R5: A bus cycle in which `bus_we_n` is low at any point while `bus_ce_n` is low counts as a write. A write returns the matcher to its first step.
- R6: A read of FIRST_ADDR that breaks a partial series counts as the first read of a new series, so the next expected address is SECOND_ADDR.
- R7: Accesses that end while `busy_o` is high neither advance the matcher nor start a command, and the matcher is at its first step when `busy_o` falls.
- R8: The command pulses are single-cycle and at most one is high in any cycle.
- R9: A complete lead-in followed by a sixth address that is neither STORE_ADDR nor 0x0F0E starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | SRAM bus address |
| bus_ce_n | input | 1 | SRAM chip enable, active low; an access is counted when it rises |
| bus_we_n | input | 1 | SRAM write enable, active low |
| store_go_o | output | 1 | One-cycle STORE start pulse |
| clear_go_o | output | 1 | One-cycle start pulse for the RECALL clear phase |
| xfer_go_o | output | 1 | One-cycle start pulse for the RECALL transfer phase |
| inhibit_o | output | 1 | Blocks SRAM access while an operation runs |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench runs clean STORE and RECALL series and measures the exact length of each busy window and the offset from the clear pulse to the transfer pulse. A design that counts one cycle off, or skips the clear phase, shows up as a wrong length. Series are broken by a stray address, by a write in the middle, and by a wrong sixth address. A matcher that does not reset would still fire a command. A restart on FIRST_ADDR is also tried, where a matcher that only reset to step one would miss the command. A complete series is issued while a STORE is still running, followed by a lone final read after it ends. A design that snooped during an operation would produce a second command.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STORE = 2'd1,
    OP_CLEAR = 2'd2,
    OP_XFER  = 2'd3
  } op_state_t;

  localparam int unsigned SEQ_LEN = 6;
  localparam logic [15:0] MID_ADDR0   = 16'h0AAA;
  localparam logic [15:0] MID_ADDR1   = 16'h1FFF;
  localparam logic [15:0] MID_ADDR2   = 16'h10F0;
  localparam logic [15:0] RECALL_ADDR = 16'h0F0E;
endpackage

// File: rtl/nvseq_bus_snoop.sv
module nvseq_bus_snoop #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  output logic              rd_evt,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] evt_addr
);
  logic              ce_q;
  logic              wseen_q, wseen_d;
  logic [ADDR_W-1:0] addr_q;
  logic              end_edge;

  // write-low seen during the current access; cleared when an access opens
  always_comb begin
    wseen_d = (ce_q ? 1'b0 : wseen_q) | ~bus_we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q    <= 1'b1;
      wseen_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      ce_q <= bus_ce_n;
      if (!bus_ce_n) begin
        wseen_q <= wseen_d;
        addr_q  <= bus_addr;
      end
    end
  end

  assign end_edge = ~ce_q & bus_ce_n;
  assign rd_evt   = end_edge & ~wseen_q;
  assign wr_evt   = end_edge & wseen_q;
  assign evt_addr = addr_q;
endmodule

// File: rtl/nvseq_matcher.sv
module nvseq_matcher
  import nvseq_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 13,
  parameter logic [15:0]    FIRST_ADDR  = 16'h0E38,
  parameter logic [15:0]    SECOND_ADDR = 16'h11C7,
  parameter logic [15:0]    STORE_ADDR  = 16'h07C1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              hold,
  output logic              hit_store,
  output logic              hit_recall
);
  localparam int unsigned STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic [ADDR_W-1:0] expect_addr;
  logic              is_first;

  always_comb begin
    case (step_q)
      STEP_W'(0): expect_addr = FIRST_ADDR[ADDR_W-1:0];
      STEP_W'(1): expect_addr = SECOND_ADDR[ADDR_W-1:0];
      STEP_W'(2): expect_addr = MID_ADDR0[ADDR_W-1:0];
      STEP_W'(3): expect_addr = MID_ADDR1[ADDR_W-1:0];
      default:    expect_addr = MID_ADDR2[ADDR_W-1:0];
    endcase
  end

  assign is_first = (evt_addr == FIRST_ADDR[ADDR_W-1:0]);

  always_comb begin
    step_d     = step_q;
    hit_store  = 1'b0;
    hit_recall = 1'b0;
    if (hold || wr_evt) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (step_q == LAST_STEP) begin
        step_d = '0;
        if (evt_addr == RECALL_ADDR[ADDR_W-1:0])      hit_recall = 1'b1;
        else if (evt_addr == STORE_ADDR[ADDR_W-1:0])  hit_store  = 1'b1;
        else if (is_first)                            step_d     = STEP_W'(1);
      end else if (evt_addr == expect_addr) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = is_first ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  p_write_resets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (step_q == '0));
  p_hold_resets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (step_q == '0));
  p_hit_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_store && hit_recall));
  p_step_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST_STEP);
endmodule

// File: rtl/nvseq_op_ctrl.sv
module nvseq_op_ctrl
  import nvseq_pkg::*;
#(
  parameter int unsigned STORE_CYCLES = 2000000,
  parameter int unsigned CLEAR_CYCLES = 400,
  parameter int unsigned XFER_CYCLES  = 3600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_store,
  input  logic hit_recall,
  output logic store_go,
  output logic clear_go,
  output logic xfer_go,
  output logic inhibit,
  output logic busy
);
  localparam int unsigned MAX_C = (STORE_CYCLES > CLEAR_CYCLES) ?
      ((STORE_CYCLES > XFER_CYCLES) ? STORE_CYCLES : XFER_CYCLES) :
      ((CLEAR_CYCLES > XFER_CYCLES) ? CLEAR_CYCLES : XFER_CYCLES);
  localparam int unsigned CW = $clog2(MAX_C + 1);

  op_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          store_d, clear_d, xfer_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    store_d = 1'b0;
    clear_d = 1'b0;
    xfer_d  = 1'b0;
    case (state_q)
      OP_IDLE: begin
        if (hit_store) begin
          state_d = OP_STORE;
          cnt_d   = CW'(STORE_CYCLES - 1);
          store_d = 1'b1;
        end else if (hit_recall) begin
          state_d = OP_CLEAR;
          cnt_d   = CW'(CLEAR_CYCLES - 1);
          clear_d = 1'b1;
        end
      end
      OP_CLEAR: begin
        if (cnt_q == '0) begin
          state_d = OP_XFER;
          cnt_d   = CW'(XFER_CYCLES - 1);
          xfer_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: begin
        if (cnt_q == '0) state_d = OP_IDLE;
        else             cnt_d   = cnt_q - CW'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= OP_IDLE;
      cnt_q    <= '0;
      store_go <= 1'b0;
      clear_go <= 1'b0;
      xfer_go  <= 1'b0;
      busy     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      store_go <= store_d;
      clear_go <= clear_d;
      xfer_go  <= xfer_d;
      busy     <= (state_d != OP_IDLE);
    end
  end

  assign inhibit = (state_q != OP_IDLE);

  p_go_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_go, clear_go, xfer_go}));
  p_store_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_go |=> !store_go);
  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (store_go || clear_go));
  p_xfer_in_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |-> (busy && inhibit));
  p_no_hit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !(hit_store || hit_recall));
endmodule

// File: rtl/nvseq_detect.sv
module nvseq_detect #(
  parameter int unsigned ADDR_W       = 13,
  parameter logic [15:0] FIRST_ADDR   = 16'h0E38,
  parameter logic [15:0] SECOND_ADDR  = 16'h11C7,
  parameter logic [15:0] STORE_ADDR   = 16'h07C1,
  parameter int unsigned STORE_CYCLES = 2000000,
  parameter int unsigned CLEAR_CYCLES = 400,
  parameter int unsigned XFER_CYCLES  = 3600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  output logic              store_go_o,
  output logic              clear_go_o,
  output logic              xfer_go_o,
  output logic              inhibit_o,
  output logic              busy_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              rd_evt, wr_evt;
  logic [ADDR_W-1:0] evt_addr;
  logic              hit_store, hit_recall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nvseq_bus_snoop #(.ADDR_W(ADDR_W)) u_snoop (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bus_addr (bus_addr),
    .bus_ce_n (bus_ce_n),
    .bus_we_n (bus_we_n),
    .rd_evt   (rd_evt),
    .wr_evt   (wr_evt),
    .evt_addr (evt_addr)
  );

  nvseq_matcher #(
    .ADDR_W      (ADDR_W),
    .FIRST_ADDR  (FIRST_ADDR),
    .SECOND_ADDR (SECOND_ADDR),
    .STORE_ADDR  (STORE_ADDR)
  ) u_match (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_evt     (rd_evt),
    .wr_evt     (wr_evt),
    .evt_addr   (evt_addr),
    .hold       (inhibit_o),
    .hit_store  (hit_store),
    .hit_recall (hit_recall)
  );

  nvseq_op_ctrl #(
    .STORE_CYCLES (STORE_CYCLES),
    .CLEAR_CYCLES (CLEAR_CYCLES),
    .XFER_CYCLES  (XFER_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hit_store  (hit_store),
    .hit_recall (hit_recall),
    .store_go   (store_go_o),
    .clear_go   (clear_go_o),
    .xfer_go    (xfer_go_o),
    .inhibit    (inhibit_o),
    .busy       (busy_o)
  );
endmodule

// File: tb/tb_nvseq_detect.sv
`timescale 1ns/1ps
module tb_nvseq_detect;
  localparam int unsigned AW = 13;
  localparam logic [15:0] FA = 16'h0E38;
  localparam logic [15:0] SA = 16'h11C7;
  localparam logic [15:0] ST = 16'h07C1;
  localparam int unsigned N_ST = 20;
  localparam int unsigned N_CL = 4;
  localparam int unsigned N_XF = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_ce_n, bus_we_n;
  logic          store_go_o, clear_go_o, xfer_go_o, inhibit_o, busy_o;

  int checks = 0;
  int fails  = 0;
  int go_seen = 0;
  int pushed  = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  nvseq_detect #(
    .ADDR_W(AW), .FIRST_ADDR(FA), .SECOND_ADDR(SA), .STORE_ADDR(ST),
    .STORE_CYCLES(N_ST), .CLEAR_CYCLES(N_CL), .XFER_CYCLES(N_XF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ce_n(bus_ce_n),
    .bus_we_n(bus_we_n), .store_go_o(store_go_o), .clear_go_o(clear_go_o),
    .xfer_go_o(xfer_go_o), .inhibit_o(inhibit_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic wr);
    @(negedge clk);
    bus_addr = a[AW-1:0];
    bus_we_n = ~wr;
    bus_ce_n = 1'b0;
    @(negedge clk);
    bus_ce_n = 1'b1;
    bus_we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a);
    access(a, 1'b0);
  endtask

  task automatic lead_in();
    rd(FA); rd(SA); rd(16'h0AAA); rd(16'h1FFF); rd(16'h10F0);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops expected ops and measures pulse spacing and busy length
  int run_len = 0;
  int run_exp = 0;
  int clr_age = -1;
  bit prev_busy = 0;
  bit prev_go = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_go) chk("R8 pulse width", store_go_o | clear_go_o, 0);
      prev_go = store_go_o | clear_go_o;
      if (store_go_o || clear_go_o) begin
        go_seen++;
        chk("R8 one pulse", int'(store_go_o) + int'(clear_go_o) + int'(xfer_go_o), 1);
        chk("R2/R3 inhibit at start", inhibit_o, 1);
        if (exp_q.size() == 0) begin
          chk("R4/R5/R7/R9 unexpected command", store_go_o ? 1 : 2, 0);
        end else begin
          int k;
          k = exp_q.pop_front();
          chk(k == 1 ? "R2 kind" : "R3 kind", store_go_o ? 1 : 2, k);
          run_exp = (k == 1) ? N_ST : N_CL + N_XF;
        end
        if (clear_go_o) clr_age = 0;
      end else if (clr_age >= 0) begin
        clr_age++;
      end
      if (xfer_go_o) begin
        chk("R3 transfer offset", clr_age, N_CL);
        clr_age = -1;
      end
      if (busy_o) run_len++;
      if (!busy_o && prev_busy) begin
        chk("R2/R3 busy length", run_len, run_exp);
        run_len = 0;
      end
      prev_busy = busy_o;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = '0;
    bus_ce_n = 1'b1;
    bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 store_go", store_go_o, 0);
    chk("R1 clear_go", clear_go_o, 0);
    chk("R1 busy", busy_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 inhibit", inhibit_o, 0);
    // R1: a lone final address right after reset does nothing
    rd(ST);
    wait_idle();
    chk("R1 idle matcher", go_seen, pushed);

    // R2 clean store
    lead_in(); exp_q.push_back(1); pushed++; rd(ST);
    wait_idle();
    chk("R2 command count", go_seen, pushed);

    // R3 clean recall
    lead_in(); exp_q.push_back(2); pushed++; rd(16'h0F0E);
    wait_idle();
    chk("R3 command count", go_seen, pushed);

    // R4 stray address aborts
    rd(FA); rd(SA); rd(16'h0AAA); rd(16'h1234); rd(16'h1FFF); rd(16'h10F0); rd(ST);
    wait_idle();
    chk("R4 abort", go_seen, pushed);

    // R5 write in the middle aborts
    rd(FA); rd(SA); rd(16'h0AAA); access(16'h1FFF, 1'b1);
    rd(16'h1FFF); rd(16'h10F0); rd(ST);
    wait_idle();
    chk("R5 write abort", go_seen, pushed);

    // R6 restart on first address
    rd(FA); rd(SA); rd(FA);
    rd(SA); rd(16'h0AAA); rd(16'h1FFF); rd(16'h10F0);
    exp_q.push_back(1); pushed++; rd(ST);
    wait_idle();
    chk("R6 restart", go_seen, pushed);

    // R9 wrong final address, then a good recall
    lead_in(); rd(16'h0F0F);
    wait_idle();
    chk("R9 wrong final", go_seen, pushed);
    lead_in(); exp_q.push_back(2); pushed++; rd(16'h0F0E);
    wait_idle();
    chk("R9 recovery", go_seen, pushed);

    // R7 series during a store is ignored
    lead_in(); exp_q.push_back(1); pushed++; rd(ST);
    chk("R7 busy during store", busy_o, 1);
    lead_in(); rd(16'h0F0E);
    wait_idle();
    rd(16'h0F0E);
    wait_idle();
    chk("R7 ignored while busy", go_seen, pushed);

    chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule